// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block holds the power state of a chip. Software asks for one of five sleep levels. The controller then drives the enables for the clocks, the memory power and retention, the core supply and the I/O hold latches that belong to that level. The three shallow levels are sleep-0, sleep-3 and sleep-4. The two shutdown levels are shutdown-3.5, which keeps only the real-time clock domain alive, and shutdown-4.5, which powers everything down.

While asleep, the controller watches the interrupt, I/O and real-time-clock wake events. It accepts only the events that the current level allows. After an accepted event it waits a per-level latency, given as a parameter in clock cycles, and then returns to active mode.

A wake from a shallow level enters an interrupt-service phase. When software signals the interrupt return, the controller goes back to the same sleep level. A wake from a shutdown level cannot resume, because the core lost its supply. It therefore ends with a one-cycle core-reset pulse and plain active mode.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the status is active (code 0), the main clock, memory power, retention and core supply are on, I/O hold is off, and `wake_done` and `core_rst` are low.
- R2: Mode codes are 0 active, 1 sleep-0, 2 sleep-3, 3 sleep-4, 4 shutdown-3.5 and 5 shutdown-4.5. In the run state, a `req_valid` with code 1 to 5 and no qualified wake pending changes `mode_stat` to that code at the next edge. Codes 0, 6 and 7 are ignored.
- R3: The events that wake each level are as follows. Sleep-0 and sleep-3 wake on any of `irq_evt`, `io_evt` or `rtc_evt`. Sleep-4 and shutdown-4.5 wake only on `io_evt`. Shutdown-3.5 wakes on `rtc_evt` or `io_evt`. Any other event leaves the level unchanged.
- R4: A qualified event sampled at edge t makes `mode_stat` read 0 after edge t+L, where L is the latency of the level (`LAT_S0` for sleep-0, `LAT_S34` for sleep-3/4, `LAT_SHD` for shutdown). Until then `mode_stat` keeps the sleep code.
- R5: A shallow wake leads to the service phase, where `mode_stat` reads 0. An `irq_ret` in that phase puts the same sleep code back at the next edge. An `irq_ret` outside that phase has no effect.
- R6: `core_rst` pulses for one cycle, together with `wake_done`, only when a wake from shutdown-3.5 or shutdown-4.5 completes. After such a wake, `irq_ret` does not return to sleep.
- R7: If a request is made while an event that qualifies for the requested level is present, the controller stays active and pulses `wake_done` at the next edge. An event that does not qualify does not block the entry.
- R8: `wake_done` is high for exactly one cycle after each completed wake.
- R9: `mclk_en` is high only when `mode_stat` is 0.
- R10: `clk_en`/`clk_req` bit order: 0 subsystem, 1 FLL, 2 DCO, 3 module, 4 auxiliary, 5 reference, 6 crystal, 7 very-low-power.
  - Bits 0 to 3 follow the request only in active and sleep-0.
  - Bits 4 and 5 also follow the request in sleep-3.
  - Bits 6 and 7 follow the request in active, sleep-0, sleep-3 and shutdown-3.5. In sleep-4 they follow it only while `lf_req` is high.
  - Every other case gives 0.
- R11: Retention outputs by level:
  - `fram_on` is high only in active and sleep-0.
  - `ram_on` is high for codes 0 to 3.
  - `bkup_on` is high except in shutdown-4.5.
  - `io_hold` is high for codes 2 to 5.
  - `core_on` is high for codes 0 to 3.
- R12: Requests made while asleep, while waking, or during the service phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | sleep request strobe |
| req_mode | input | 3 | requested level code |
| irq_evt | input | 1 | general interrupt event |
| io_evt | input | 1 | I/O pin wake event |
| rtc_evt | input | 1 | real-time-clock wake event |
| irq_ret | input | 1 | interrupt-return strobe |
| clk_req | input | 8 | per-clock enable requests |
| lf_req | input | 1 | low-frequency peripheral clock demand |
| mclk_en | output | 1 | main CPU clock enable |
| clk_en | output | 8 | optional clock enables |
| fram_on | output | 1 | nonvolatile memory power |
| ram_on | output | 1 | RAM retention |
| bkup_on | output | 1 | backup register retention |
| io_hold | output | 1 | I/O output latch hold |
| core_on | output | 1 | core supply enable |
| core_rst | output | 1 | core restart pulse after a shutdown wake |
| mode_stat | output | 3 | current level code |
| wake_done | output | 1 | wake completion pulse |

## Verification
The bench pairs every level with both a qualifying event and a non-qualifying one. A wrong qualification table would show up in one of two ways: a level wakes when it should not, or it stays asleep on a valid event. The bench then counts the latency down to the exact edge, so a counter that is off by one, or one that starts at the wrong time, reports the active code one cycle early or late. The bench also checks three other corner cases:
- An event already pending when a request is made. A design that ignores it would go to sleep.
- A request made during the service phase. A design that accepts it would skip the return to sleep.
- The conditional crystal gating in sleep-4, controlled by `lf_req`.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE = 3'd0,
        PM_SLP0   = 3'd1,
        PM_SLP3   = 3'd2,
        PM_SLP4   = 3'd3,
        PM_SHD35  = 3'd4,
        PM_SHD45  = 3'd5
    } pm_mode_e;

    typedef enum logic [1:0] {
        SQ_RUN,
        SQ_SLEEP,
        SQ_WAKE,
        SQ_ISR
    } sq_state_e;

    localparam int NCLK = 8;

    typedef struct packed {
        logic            core_on;
        logic            io_hold;
        logic            bkup_on;
        logic            ram_on;
        logic            fram_on;
        logic [NCLK-1:0] clk_en;
        logic            mclk_en;
    } pm_gate_t;

    function automatic logic is_sleep_code(input logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd5);
    endfunction

    function automatic logic is_shutdown(input pm_mode_e m);
        return (m == PM_SHD35) || (m == PM_SHD45);
    endfunction

    // clock class: 0 = fast group, 1 = aux/ref group, 2 = low-frequency group
    function automatic int clk_class(input int idx);
        return (idx < 4) ? 0 : ((idx < 6) ? 1 : 2);
    endfunction

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
    import pwr_mode_pkg::*;
(
    input  pm_mode_e mode,
    input  logic     irq_evt,
    input  logic     io_evt,
    input  logic     rtc_evt,
    output logic     hit
);
    always_comb begin
        case (mode)
            PM_SLP0, PM_SLP3: hit = irq_evt | io_evt | rtc_evt;
            PM_SLP4:          hit = io_evt;
            PM_SHD35:         hit = io_evt | rtc_evt;
            PM_SHD45:         hit = io_evt;
            default:          hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwr_gate_map.sv
module pwr_gate_map
    import pwr_mode_pkg::*;
(
    input  pm_mode_e        mode,
    input  logic [NCLK-1:0] clk_req,
    input  logic            lf_req,
    output pm_gate_t        gate
);
    logic [2:0] m;
    logic       lvl_fast;
    logic       lvl_aux;
    logic       lvl_lf;

    assign m        = mode;
    assign lvl_fast = (m <= 3'd1);
    assign lvl_aux  = (m <= 3'd2);
    assign lvl_lf   = (m <= 3'd2) || (mode == PM_SHD35) || ((mode == PM_SLP4) && lf_req);

    for (genvar i = 0; i < NCLK; i++) begin : g_clk
        if (clk_class(i) == 0) begin : g_fast
            assign gate.clk_en[i] = clk_req[i] & lvl_fast;
        end else if (clk_class(i) == 1) begin : g_aux
            assign gate.clk_en[i] = clk_req[i] & lvl_aux;
        end else begin : g_lf
            assign gate.clk_en[i] = clk_req[i] & lvl_lf;
        end
    end

    assign gate.mclk_en = (mode == PM_ACTIVE);
    assign gate.fram_on = lvl_fast;
    assign gate.ram_on  = (m <= 3'd3);
    assign gate.bkup_on = (mode != PM_SHD45);
    assign gate.io_hold = (m >= 3'd2);
    assign gate.core_on = (m <= 3'd3);
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int LAT_S0  = 0,
    parameter int LAT_S34 = 2500,
    parameter int LAT_SHD = 87500
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [2:0]      req_mode,
    input  logic            irq_evt,
    input  logic            io_evt,
    input  logic            rtc_evt,
    input  logic            irq_ret,
    input  logic [NCLK-1:0] clk_req,
    input  logic            lf_req,
    output logic            mclk_en,
    output logic [NCLK-1:0] clk_en,
    output logic            fram_on,
    output logic            ram_on,
    output logic            bkup_on,
    output logic            io_hold,
    output logic            core_on,
    output logic            core_rst,
    output logic [2:0]      mode_stat,
    output logic            wake_done
);
    localparam int MAXLAT = (LAT_SHD > LAT_S34) ? ((LAT_SHD > LAT_S0) ? LAT_SHD : LAT_S0)
                                                : ((LAT_S34 > LAT_S0) ? LAT_S34 : LAT_S0);
    localparam int CW = (MAXLAT < 2) ? 1 : $clog2(MAXLAT + 1);

    sq_state_e st;
    pm_mode_e  cur_mode;
    pm_mode_e  req_m;
    pm_mode_e  eff_mode;
    logic      wake_done_q;
    logic      core_rst_q;
    logic      req_hit;
    logic      slp_hit;
    logic      req_ok;
    logic      t_zero;
    logic      t_load;
    logic      t_dec;
    logic      lat_zero;
    logic [CW-1:0] lat_sel;
    pm_gate_t  gate;

    function automatic logic [CW-1:0] lat_of(input pm_mode_e m);
        case (m)
            PM_SLP0:           return CW'(LAT_S0);
            PM_SLP3, PM_SLP4:  return CW'(LAT_S34);
            PM_SHD35, PM_SHD45: return CW'(LAT_SHD);
            default:           return '0;
        endcase
    endfunction

    assign req_m    = pm_mode_e'(req_mode);
    assign req_ok   = (st == SQ_RUN) && req_valid && is_sleep_code(req_mode);
    assign lat_sel  = lat_of(cur_mode);
    assign lat_zero = (lat_sel == '0);
    assign t_load   = (st == SQ_SLEEP) && slp_hit && !lat_zero;
    assign t_dec    = (st == SQ_WAKE) && !t_zero;

    pwr_wake_qual u_req_qual (
        .mode(req_m), .irq_evt(irq_evt), .io_evt(io_evt), .rtc_evt(rtc_evt), .hit(req_hit)
    );

    pwr_wake_qual u_slp_qual (
        .mode(cur_mode), .irq_evt(irq_evt), .io_evt(io_evt), .rtc_evt(rtc_evt), .hit(slp_hit)
    );

    pwr_wake_timer #(.W(CW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(lat_sel - 1'b1),
        .dec(t_dec), .zero(t_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= SQ_RUN;
            cur_mode    <= PM_ACTIVE;
            wake_done_q <= 1'b0;
            core_rst_q  <= 1'b0;
        end else begin
            wake_done_q <= 1'b0;
            core_rst_q  <= 1'b0;
            case (st)
                SQ_RUN: begin
                    if (req_ok) begin
                        if (req_hit) begin
                            wake_done_q <= 1'b1;
                        end else begin
                            st       <= SQ_SLEEP;
                            cur_mode <= req_m;
                        end
                    end
                end
                SQ_SLEEP, SQ_WAKE: begin
                    if ((st == SQ_SLEEP && slp_hit && lat_zero) || (st == SQ_WAKE && t_zero)) begin
                        wake_done_q <= 1'b1;
                        if (is_shutdown(cur_mode)) begin
                            core_rst_q <= 1'b1;
                            st         <= SQ_RUN;
                            cur_mode   <= PM_ACTIVE;
                        end else begin
                            st <= SQ_ISR;
                        end
                    end else if (st == SQ_SLEEP && slp_hit) begin
                        st <= SQ_WAKE;
                    end
                end
                SQ_ISR: begin
                    if (irq_ret) st <= SQ_SLEEP;
                end
                default: st <= SQ_RUN;
            endcase
        end
    end

    assign eff_mode = (st == SQ_SLEEP || st == SQ_WAKE) ? cur_mode : PM_ACTIVE;

    pwr_gate_map u_gate (
        .mode(eff_mode), .clk_req(clk_req), .lf_req(lf_req), .gate(gate)
    );

    assign mclk_en   = gate.mclk_en;
    assign clk_en    = gate.clk_en;
    assign fram_on   = gate.fram_on;
    assign ram_on    = gate.ram_on;
    assign bkup_on   = gate.bkup_on;
    assign io_hold   = gate.io_hold;
    assign core_on   = gate.core_on;
    assign core_rst  = core_rst_q;
    assign wake_done = wake_done_q;
    assign mode_stat = eff_mode;

    AST_MCLK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst) (mode_stat != 3'd0) |-> !mclk_en); // R9
    AST_RST_WITH_DONE: assert property (@(posedge clk) disable iff (rst) core_rst |-> wake_done); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) wake_done |=> !wake_done); // R8
    AST_FRAM_OFF_DEEP: assert property (@(posedge clk) disable iff (rst) (mode_stat >= 3'd2) |-> !fram_on); // R11
    AST_CORE_OFF_SHD: assert property (@(posedge clk) disable iff (rst) !core_on |-> (mode_stat >= 3'd4)); // R11
    AST_RET_SAME_MODE: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_ISR && irq_ret) |=> (mode_stat == $past(cur_mode))); // R5
    AST_SLEEP_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_SLEEP && !slp_hit) |=> (mode_stat == $past(mode_stat))); // R12
endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
    localparam int L0 = 0;
    localparam int L34 = 5;
    localparam int LSD = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_mode = 3'd0;
    logic       irq_evt = 1'b0, io_evt = 1'b0, rtc_evt = 1'b0, irq_ret = 1'b0;
    logic [7:0] clk_req = 8'hFF;
    logic       lf_req = 1'b0;
    logic       mclk_en, fram_on, ram_on, bkup_on, io_hold, core_on, core_rst, wake_done;
    logic [7:0] clk_en;
    logic [2:0] mode_stat;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_seq #(.LAT_S0(L0), .LAT_S34(L34), .LAT_SHD(LSD)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .irq_evt(irq_evt), .io_evt(io_evt), .rtc_evt(rtc_evt), .irq_ret(irq_ret),
        .clk_req(clk_req), .lf_req(lf_req), .mclk_en(mclk_en), .clk_en(clk_en),
        .fram_on(fram_on), .ram_on(ram_on), .bkup_on(bkup_on), .io_hold(io_hold),
        .core_on(core_on), .core_rst(core_rst), .mode_stat(mode_stat), .wake_done(wake_done)
    );

    // fields: mode[6:4], irq[3], io[2], rtc[1], expect_wake[0]
    localparam logic [6:0] VEC [0:11] = '{
        {3'd1, 4'b1001}, {3'd1, 4'b0011}, {3'd2, 4'b1001}, {3'd3, 4'b1000},
        {3'd3, 4'b0010}, {3'd3, 4'b0101}, {3'd4, 4'b0011}, {3'd4, 4'b1000},
        {3'd5, 4'b0010}, {3'd5, 4'b0101}, {3'd2, 4'b0011}, {3'd4, 4'b0101}
    };

    function automatic int lat_b(input int m);
        return (m == 1) ? L0 : ((m == 2 || m == 3) ? L34 : LSD);
    endfunction

    function automatic logic [13:0] expg(input int m, input logic [7:0] rq, input logic lf);
        logic s0, s3, xt;
        s0 = (m <= 1);
        s3 = (m <= 2);
        xt = (m <= 2) || (m == 4) || ((m == 3) && lf);
        return {m < 4, m >= 2, m != 5, m <= 3, s0,
                rq[7] & xt, rq[6] & xt, rq[5] & s3, rq[4] & s3, rq[3:0] & {4{s0}},
                m == 0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0; irq_evt = 1'b0; io_evt = 1'b0; rtc_evt = 1'b0; irq_ret = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic request(input logic [2:0] m);
        req_valid = 1'b1; req_mode = m;
        tick();
        req_valid = 1'b0;
    endtask

    function automatic logic [13:0] gates();
        return {core_on, io_hold, bkup_on, ram_on, fram_on, clk_en, mclk_en};
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 mode", 32'(mode_stat), 0);
        chk("R1 gates", 32'(gates()), 32'(expg(0, 8'hFF, 1'b0)));
        chk("R1 pulses", {wake_done, core_rst}, 0);

        // R2: invalid codes ignored
        request(3'd0);
        chk("R2 code0", 32'(mode_stat), 0);
        request(3'd6);
        chk("R2 code6", 32'(mode_stat), 0);
        request(3'd7);
        chk("R2 code7", 32'(mode_stat), 0);

        // R10: partial request pattern in active
        clk_req = 8'hA5; #1;
        chk("R10 active pattern", 32'(clk_en), 32'hA5);
        clk_req = 8'hFF;

        // vector table walk
        for (int v = 0; v < 12; v++) begin
            int m;
            logic wk;
            do_reset();
            m  = int'(VEC[v][6:4]);
            wk = VEC[v][0];
            request(3'(m));
            chk("R2 entry", 32'(mode_stat), 32'(m));
            chk("R10 R11 gates", 32'(gates()), 32'(expg(m, 8'hFF, 1'b0)));
            irq_evt = VEC[v][3]; io_evt = VEC[v][2]; rtc_evt = VEC[v][1];
            tick();
            irq_evt = 1'b0; io_evt = 1'b0; rtc_evt = 1'b0;
            if (!wk) begin
                chk("R3 no wake", {29'd0, mode_stat}, 32'(m));
                chk("R3 no done", 32'(wake_done), 0);
                io_evt = 1'b1;
                tick();
                io_evt = 1'b0;
            end
            for (int i = 0; i < lat_b(m); i++) begin
                chk("R4 still waking", 32'(mode_stat), 32'(m));
                tick();
            end
            chk("R4 active after latency", 32'(mode_stat), 0);
            chk("R8 done", 32'(wake_done), 1);
            chk("R6 core_rst", 32'(core_rst), 32'(m >= 4));
            tick();
            chk("R8 done drops", 32'(wake_done), 0);
            irq_ret = 1'b1;
            tick();
            irq_ret = 1'b0;
            chk("R5 R6 return", 32'(mode_stat), (m < 4) ? 32'(m) : 0);
        end

        // R7: pending qualified event makes an immediate wake
        do_reset();
        io_evt = 1'b1;
        request(3'd3);
        io_evt = 1'b0;
        chk("R7 stays active", 32'(mode_stat), 0);
        chk("R7 done pulse", 32'(wake_done), 1);
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
        chk("R5 ret ignored in run", 32'(mode_stat), 0);

        // R7: non-qualifying pending event does not block the entry
        irq_evt = 1'b1;
        request(3'd3);
        irq_evt = 1'b0;
        chk("R7 unqualified enters", 32'(mode_stat), 3);

        // R10: conditional low-frequency clocks in sleep-4
        lf_req = 1'b1; #1;
        chk("R10 lf on", 32'(clk_en), 32'hC0);
        lf_req = 1'b0; #1;
        chk("R10 lf off", 32'(clk_en), 0);

        // R12: request while asleep ignored
        request(3'd1);
        chk("R12 sleep req", 32'(mode_stat), 3);

        // R12: request during service ignored
        do_reset();
        request(3'd2);
        irq_evt = 1'b1;
        tick();
        irq_evt = 1'b0;
        for (int i = 0; i < L34; i++) tick();
        chk("R5 in service", 32'(mode_stat), 0);
        request(3'd5);
        chk("R12 isr req", 32'(mode_stat), 0);
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
        chk("R5 back to sleep-3", 32'(mode_stat), 2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule